// File: doc/BRIEF.md
# Prescaled Match Timer Pair

This block holds two independent 16-bit up-counting timers behind a plain synchronous register port. Each timer is set up through a control word: a prescale code dividing the shared functional clock by a power of two, a run bit, a repeat-or-single-shot choice and an interrupt mask. A load word gives the match value. When the running count equals the load value on a prescaled tick, a sticky match flag is raised and the count goes back to zero.

In repeat mode the timer keeps running, which yields a periodic event every load+1 ticks. In single-shot mode the match also drops the run bit, so the timer stops after one interval. Software clears the flag by writing a one to it. Each timer drives its own interrupt line, which is the flag gated by the mask. Loading 0xFFFF turns a timer into a free-running 16-bit time base.

Top module: `match_timer_pair`

## Requirements
- R1: After reset every register of both timers reads 0 and both interrupt lines are low.
- R2: Control bits [3:0] hold the prescale code c (0 to 8). While a timer runs, its count advances once every 2^c clock cycles. The first advance comes 2^c cycles after the edge that starts it.
- R3: Control bit 5 is the run bit. Writing it from 0 to 1 restarts the count at 0. Writing it to 0 stops the count, and the count register keeps its value.
- R4: When a prescaled tick finds the count equal to the load value, the status flag is set and the count returns to 0. With control bit 4 at 0 (repeat), the timer keeps running.
- R5: The match flag is bit 0 of the status register. Writing 1 there clears it. Writing 0 has no effect. A match on the same edge as a clearing write leaves the flag set.
- R6: A timer's interrupt line is high exactly when its match flag is set and its mask bit (control bit 6) is 1.
- R7: With control bit 4 at 1 (single shot), a match clears the run bit, and the count then stays at 0.
- R8: Writing the load register sets the match value and restarts the count and the prescale phase from 0.
- R9: A control write whose code field is above 8 leaves the stored code unchanged. The other control bits still take the written values.
- R10: Address bit 2 selects the timer; bits [1:0] select control (0), load (1), status (2) or count (3). Activity in one timer never changes the other.
- R11: Writing 0 to control, 0 to load and 1 to status returns a timer to an all-zero state with its interrupt low.
- R12: With load 0xFFFF and code 0, the count reaches 0xFFFF after 65535 cycles. On the next cycle it wraps to 0 and sets the flag.
- R13: Writes to the count register have no effect. Unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared functional and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Timer select (bit 2) and register select (bits 1:0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 2 | Per-timer interrupt, flag AND mask |

## Verification
A wrong count or prescale phase appears on the count register during the same cycle. It reaches the interrupt line no later than one interval later, when the match lands on the wrong edge. A lost run bit or a stale flag shows up at once in the control and status reads and in the interrupt line. To catch these, a per-cycle reference model of both timers compares the interrupt lines and the addressed register after every clock edge. Directed checks add hand-computed values at the match, wrap, single-shot and clear-collision edges.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
   // field layout of the control word
   localparam int CODE_W   = 4;
   localparam int MODE_BIT = 4;
   localparam int RUN_BIT  = 5;
   localparam int MASK_BIT = 6;
   localparam int FLAG_BIT = 0;

   typedef enum logic [1:0] {
      RG_CTRL  = 2'd0,
      RG_LOAD  = 2'd1,
      RG_STAT  = 2'd2,
      RG_COUNT = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/mt_prescaler.sv
`timescale 1ns/1ps
module mt_prescaler #(
   parameter int MAX_CODE = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      restart,
   input  logic [mt_pkg::CODE_W-1:0] code,
   output logic                      tick
);
   localparam int DIV_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W:0]   mask_w;

   // low 'code' bits all ones marks the last cycle of a 2^code period
   assign mask_w = ((DIV_W+1)'(1) << code) - (DIV_W+1)'(1);
   assign tick   = run && ((div_q & mask_w[DIV_W-1:0]) == mask_w[DIV_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              div_q <= '0;
      else if (!run || restart) div_q <= '0;
      else                     div_q <= div_q + 1'b1;
   end

   p_idle_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (div_q == '0));
endmodule

// File: rtl/mt_channel.sv
`timescale 1ns/1ps
module mt_channel #(
   parameter int DATA_W   = 16,
   parameter int MAX_CODE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_reg,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   import mt_pkg::*;

   logic [CODE_W-1:0] code_q;
   logic              single_q, run_q, mask_q, flag_q;
   logic [DATA_W-1:0] load_q, cnt_q;
   logic              ctrl_wr, load_wr, stat_wr, start, tick, hit;

   assign ctrl_wr = wr_en && (wr_reg == RG_CTRL);
   assign load_wr = wr_en && (wr_reg == RG_LOAD);
   assign stat_wr = wr_en && (wr_reg == RG_STAT);
   assign start   = ctrl_wr && !run_q && wr_data[RUN_BIT];
   assign hit     = tick && (cnt_q == load_q);

   mt_prescaler #(.MAX_CODE(MAX_CODE)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .restart (start || load_wr),
      .code    (code_q),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         single_q <= 1'b0;
         run_q    <= 1'b0;
         mask_q   <= 1'b0;
         load_q   <= '0;
         cnt_q    <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (ctrl_wr && (wr_data[CODE_W-1:0] <= CODE_W'(MAX_CODE)))
            code_q <= wr_data[CODE_W-1:0];
         if (ctrl_wr) begin
            single_q <= wr_data[MODE_BIT];
            mask_q   <= wr_data[MASK_BIT];
            run_q    <= wr_data[RUN_BIT];
         end else if (hit && single_q) begin
            run_q <= 1'b0;
         end
         if (load_wr) load_q <= wr_data;
         if (load_wr || start) cnt_q <= '0;
         else if (hit)         cnt_q <= '0;
         else if (tick)        cnt_q <= cnt_q + 1'b1;
         // a match on the same edge wins over a clearing write
         if (hit)                                flag_q <= 1'b1;
         else if (stat_wr && wr_data[FLAG_BIT])  flag_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_reg)
         RG_CTRL: begin
            rd_data[CODE_W-1:0] = code_q;
            rd_data[MODE_BIT]   = single_q;
            rd_data[RUN_BIT]    = run_q;
            rd_data[MASK_BIT]   = mask_q;
         end
         RG_LOAD:  rd_data = load_q;
         RG_STAT:  rd_data[FLAG_BIT] = flag_q;
         RG_COUNT: rd_data = cnt_q;
         default:  rd_data = '0;
      endcase
   end

   assign irq = flag_q && mask_q;

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= load_q);
   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !load_wr && !ctrl_wr) |=> $stable(cnt_q));
   p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && single_q && !ctrl_wr) |=> (!run_q && cnt_q == '0));
   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(stat_wr && wr_data[FLAG_BIT])) |=> flag_q);
   p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (cnt_q == '0));
   p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      code_q <= CODE_W'(MAX_CODE));
endmodule

// File: rtl/mt_readmux.sv
`timescale 1ns/1ps
module mt_readmux #(
   parameter int NUM_SRC = 2,
   parameter int DATA_W  = 16,
   parameter int SEL_W   = 1
) (
   input  logic [NUM_SRC*DATA_W-1:0] src,
   input  logic [SEL_W-1:0]          sel,
   output logic [DATA_W-1:0]         q
);
   always_comb begin
      q = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (sel == SEL_W'(i)) q = src[i*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/match_timer_pair.sv
`timescale 1ns/1ps
module match_timer_pair #(
   parameter int NUM_TIMERS = 2,
   parameter int DATA_W     = 16,
   parameter int MAX_CODE   = 8,
   parameter int ADDR_W     = $clog2(NUM_TIMERS) + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic [NUM_TIMERS-1:0] irq
);
   localparam int SEL_W = ADDR_W - 2;

   if (NUM_TIMERS < 2) begin : g_bad_count
      $error("match_timer_pair: NUM_TIMERS must be at least 2");
   end
   if (DATA_W < mt_pkg::MASK_BIT + 1) begin : g_bad_width
      $error("match_timer_pair: DATA_W too narrow for the control fields");
   end
   if (MAX_CODE < 1 || MAX_CODE >= (1 << mt_pkg::CODE_W)) begin : g_bad_code
      $error("match_timer_pair: MAX_CODE must fit the code field");
   end

   logic [SEL_W-1:0]             sel;
   logic [NUM_TIMERS*DATA_W-1:0] rd_flat;

   assign sel = reg_addr[ADDR_W-1:2];

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
      mt_channel #(.DATA_W(DATA_W), .MAX_CODE(MAX_CODE)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && (sel == SEL_W'(i))),
         .wr_reg  (reg_addr[1:0]),
         .wr_data (reg_wdata),
         .rd_reg  (reg_addr[1:0]),
         .rd_data (rd_flat[i*DATA_W +: DATA_W]),
         .irq     (irq[i])
      );
   end

   mt_readmux #(.NUM_SRC(NUM_TIMERS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rmux (
      .src (rd_flat),
      .sel (sel),
      .q   (reg_rdata)
   );
endmodule

// File: tb/sim_match_timer_pair.sv
`timescale 1ns/1ps
module sim_match_timer_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [1:0]  irq;

   always #5 clk = ~clk;  // 100 MHz

   match_timer_pair u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // behavioural reference of both timers
   int m_code[2], m_mode[2], m_run[2], m_mask[2];
   int m_load[2], m_cnt[2], m_div[2], m_flag[2];

   always @(posedge clk) begin
      for (int t = 0; t < 2; t++) begin
         int per, was_run;
         bit tk, mt;
         if (!rst_n) begin
            m_code[t] = 0; m_mode[t] = 0; m_run[t] = 0; m_mask[t] = 0;
            m_load[t] = 0; m_cnt[t] = 0; m_div[t] = 0; m_flag[t] = 0;
         end else begin
            per     = 1 << m_code[t];
            was_run = m_run[t];
            tk      = (m_run[t] != 0) && ((m_div[t] % per) == per - 1);
            mt      = tk && (m_cnt[t] == m_load[t]);
            m_div[t] = (m_run[t] != 0) ? (m_div[t] + 1) % 256 : 0;
            if (mt) begin
               m_flag[t] = 1; m_cnt[t] = 0;
               if (m_mode[t] != 0) m_run[t] = 0;
            end else if (tk) m_cnt[t] = m_cnt[t] + 1;
            if (reg_we && int'(reg_addr[2]) == t) begin
               case (reg_addr[1:0])
                  2'd0: begin
                     if (reg_wdata[3:0] <= 4'd8) m_code[t] = int'(reg_wdata[3:0]);
                     m_mode[t] = int'(reg_wdata[4]);
                     m_mask[t] = int'(reg_wdata[6]);
                     if (was_run == 0 && reg_wdata[5]) begin m_cnt[t] = 0; m_div[t] = 0; end
                     m_run[t] = int'(reg_wdata[5]);
                  end
                  2'd1: begin m_load[t] = int'(reg_wdata); m_cnt[t] = 0; m_div[t] = 0; end
                  2'd2: if (reg_wdata[0] && !mt) m_flag[t] = 0;
                  default: ;
               endcase
            end
         end
      end
   end

   function automatic int model_rd(input logic [2:0] a);
      int t = int'(a[2]);
      case (a[1:0])
         2'd0: return m_code[t] | (m_mode[t] << 4) | (m_run[t] << 5) | (m_mask[t] << 6);
         2'd1: return m_load[t];
         2'd2: return m_flag[t];
         default: return m_cnt[t];
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string rq;
         for (int t = 0; t < 2; t++)
            chk("R6", $sformatf("model irq%0d", t), int'(irq[t]), int'(m_flag[t] != 0 && m_mask[t] != 0));
         case (reg_addr[1:0])
            2'd0: rq = "R2"; 2'd1: rq = "R8"; 2'd2: rq = "R5"; default: rq = "R3";
         endcase
         chk(rq, $sformatf("model read addr %0d", reg_addr), int'(reg_rdata), model_rd(reg_addr));
      end
   end

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      reg_addr = a; #1; v = int'(reg_rdata);
   endtask

   localparam logic [2:0] C0 = 3'd0, L0 = 3'd1, S0 = 3'd2, N0 = 3'd3;
   localparam logic [2:0] C1 = 3'd4, L1 = 3'd5, S1 = 3'd6, N1 = 3'd7;

   initial begin
      int v;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v); chk("R1", $sformatf("reset reg %0d", a), v, 0);
      end
      chk("R1", "reset irq", int'(irq), 0);

      // R3: start counting from 0, code 0
      bus_wr(L0, 16'd100);
      bus_wr(C0, 16'h0020);
      idle(10);
      rd(N0, v); chk("R3", "count after 10 cycles", v, 10);
      bus_wr(C0, 16'h0000);          // tick on this edge too -> 11
      idle(5);
      rd(N0, v); chk("R3", "count held after stop", v, 11);

      // R2: code 2 -> one advance per 4 cycles
      bus_wr(C0, 16'h0022);
      idle(12);
      rd(N0, v); chk("R2", "count with code 2", v, 3);
      idle(1);
      rd(N0, v); chk("R2", "count between ticks", v, 3);

      // R9: illegal code keeps the field
      bus_wr(C0, 16'h0029);
      rd(C0, v); chk("R9", "ctrl after code 9", v, 16'h0022);
      // R13: unused control bits read zero
      bus_wr(C0, 16'hFF82);
      rd(C0, v); chk("R13", "unused ctrl bits", v, 16'h0002);

      // R8: load write restarts
      bus_wr(C0, 16'h0022);
      idle(9);
      bus_wr(L0, 16'd50);
      rd(N0, v); chk("R8", "count after load write", v, 0);

      // R4 / R6: repeat-mode match
      bus_wr(C0, 16'h0000);
      bus_wr(S0, 16'h0001);
      bus_wr(L0, 16'd5);
      bus_wr(C0, 16'h0060);
      idle(5);
      rd(N0, v); chk("R4", "count at load value", v, 5);
      rd(S0, v); chk("R4", "flag before match", v, 0);
      idle(1);
      rd(N0, v); chk("R4", "count after match", v, 0);
      rd(S0, v); chk("R4", "flag after match", v, 1);
      chk("R6", "irq0 after match", int'(irq[0]), 1);
      idle(3);
      rd(N0, v); chk("R4", "repeat mode keeps counting", v, 3);

      // R5: write 0 no effect, write 1 clears
      bus_wr(S0, 16'h0000);
      rd(S0, v); chk("R5", "flag after writing 0", v, 1);
      bus_wr(S0, 16'h0001);
      rd(S0, v); chk("R5", "flag after writing 1", v, 0);
      chk("R6", "irq0 after clear", int'(irq[0]), 0);

      // R6: mask off hides a set flag
      idle(1);
      rd(S0, v); chk("R6", "flag set again", v, 1);
      bus_wr(C0, 16'h0020);
      chk("R6", "irq0 masked", int'(irq[0]), 0);

      // R7: single shot
      bus_wr(C0, 16'h0000);
      bus_wr(S0, 16'h0001);
      bus_wr(L0, 16'd3);
      bus_wr(C0, 16'h0070);
      idle(4);
      rd(S0, v); chk("R7", "single-shot flag", v, 1);
      rd(C0, v); chk("R7", "run bit dropped", v, 16'h0050);
      chk("R7", "single-shot irq0", int'(irq[0]), 1);
      idle(6);
      rd(N0, v); chk("R7", "count stays 0", v, 0);

      // R10: timer 1 unaffected by timer 0 traffic
      bus_wr(L1, 16'd1000);
      bus_wr(C1, 16'h0020);
      bus_wr(C0, 16'h0000);
      idle(8);
      rd(N1, v); chk("R10", "timer1 count", v, 9);
      rd(S0, v); chk("R10", "timer0 flag kept", v, 1);
      chk("R10", "timer1 irq low", int'(irq[1]), 0);

      // R5: match beats clear on the same edge
      bus_wr(S0, 16'h0001);
      bus_wr(L0, 16'd2);
      bus_wr(C0, 16'h0020);
      idle(5);
      bus_wr(S0, 16'h0001);
      rd(S0, v); chk("R5", "match wins over clear", v, 1);

      // R11: clean state for both timers
      for (int t = 0; t < 2; t++) begin
         bus_wr(3'(t*4 + 0), 16'h0000);
         bus_wr(3'(t*4 + 1), 16'h0000);
         bus_wr(3'(t*4 + 2), 16'h0001);
         for (int r = 0; r < 4; r++) begin
            rd(3'(t*4 + r), v); chk("R11", $sformatf("clean t%0d reg %0d", t, r), v, 0);
         end
         chk("R11", "clean irq", int'(irq[t]), 0);
      end

      // R12: free-running wrap
      bus_wr(L1, 16'hFFFF);
      bus_wr(C1, 16'h0020);
      idle(65535);
      rd(N1, v); chk("R12", "count at top", v, 16'hFFFF);
      rd(S1, v); chk("R12", "no flag before wrap", v, 0);
      idle(1);
      rd(N1, v); chk("R12", "count wrapped", v, 0);
      rd(S1, v); chk("R12", "flag at wrap", v, 1);

      // R13: count register ignores writes
      bus_wr(C1, 16'h0000);
      bus_wr(N1, 16'h1234);
      rd(N1, v); chk("R13", "count write ignored", v, 1);

      idle(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule